// File: doc/BRIEF.md
# USB Device Endpoint Control/Status Register

This block holds the per-endpoint control and status word of a full-speed USB device controller. Software sees it as one 32-bit location on a simple register bus: a write strobe with write data, and a read port that always presents the current value. A separate transaction engine, which is not part of this block, reports completed traffic through single-cycle event pulses. These pulses cover a successful IN, a successful OUT, an accepted SETUP, and the end of an isochronous data packet in either direction.

The word combines three kinds of software write behaviour. The address, type and kind fields take plain read/write values. The status pairs and the data-toggle bits flip wherever a 1 is written. The two valid-transaction flags can only be cleared by software. Hardware events then act on top of the software write. They force status fields to NAK, flip or preset the toggles, set the valid flags, and latch whether the last receive was a SETUP.

The block drives every field out as its own port. It also drives an interrupt request, and a reject signal that tells the transaction engine to answer non-empty OUT packets with STALL.

Top module: `ep_ctrl_reg`

## Requirements
- R1: After reset, the read word is all zeros, and both `irq` and `out_stall` are 0.
- R2: A write loads address (bits 3:0), kind (bit 8) and type (bits 10:9) directly. Type codes are 00 bulk, 01 control, 10 isochronous and 11 interrupt. Bit 11 and bits 31:16 ignore written data, and bits 31:16 always read 0.
- R3: The transmit status (bits 5:4), transmit toggle (bit 6), receive status (bits 13:12) and receive toggle (bit 14) change only by toggle-on-write. A written 1 inverts a bit and a written 0 keeps it. Status codes are 00 disabled, 01 stall, 10 NAK and 11 valid.
- R4: The transmit-valid flag (bit 7) and receive-valid flag (bit 15) are cleared by writing 0, and are kept when 1 is written.
- R5: A successful IN sets the transmit-valid flag. On a non-isochronous endpoint, it also forces the transmit status to NAK and flips the transmit toggle.
- R6: A successful OUT sets the receive-valid flag. On a non-isochronous endpoint, it also forces the receive status to NAK and flips the receive toggle.
- R7: An accepted SETUP on a control endpoint sets the receive-valid flag, forces the receive status to NAK, sets the transmit toggle to 1 and clears the receive toggle. On any other type, a SETUP pulse changes nothing.
- R8: On an isochronous endpoint, completions never change either status field. An end-of-packet pulse flips the toggle of its own direction. End-of-packet pulses have no effect on other types.
- R9: The SETUP flag (bit 11) changes only on a control endpoint whose receive-valid flag reads 0. A SETUP sets it and an OUT clears it. While the receive-valid flag is 1, the SETUP flag is frozen.
- R10: `out_stall` is 1 exactly when the type is control and the kind bit is set.
- R11: `irq` is 1 exactly when at least one valid flag is 1.
- R12: When a write and an event fall in the same cycle, the software effect is applied first and the hardware effect on top of it. Event decisions use the type and the receive-valid flag held before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| ev_in_ok | input | 1 | IN transaction completed with ACK |
| ev_out_ok | input | 1 | OUT transaction accepted (ACK sent, PID matched) |
| ev_setup_ok | input | 1 | SETUP transaction accepted |
| ev_iso_tx_eop | input | 1 | Isochronous transmit packet finished |
| ev_iso_rx_eop | input | 1 | Isochronous receive packet finished |
| rd_data | output | 32 | Current register word |
| ep_addr | output | 4 | Endpoint address field |
| ep_type | output | 2 | Endpoint type field |
| ep_kind | output | 1 | Kind bit |
| tx_status | output | 2 | Transmit status field |
| tx_toggle | output | 1 | Transmit data toggle |
| rx_status | output | 2 | Receive status field |
| rx_toggle | output | 1 | Receive data toggle |
| setup_seen | output | 1 | Last receive completion was a SETUP |
| out_stall | output | 1 | Answer non-empty OUT with STALL |
| irq | output | 1 | Endpoint interrupt request |

## Verification
Several rules are checked on every cycle by the assertions. These are the match between the interrupt and the valid flags, the freezing of the SETUP flag, the NAK forcing after an IN, the toggle presets of a SETUP, the isochronous status hold, the setting of valid flags by completions, and software clearing of the transmit flag.

Only the bench's scenarios can show the full word-level effects of writes. These include the toggle-on-write arithmetic across every bit pattern and the ignored bits. They also include how a write combines with each mix of events in the same cycle, and the null effect of SETUP and end-of-packet pulses on the wrong endpoint type. The bench sweeps every type, every combination of the five event pulses and several prior flag states against an arithmetic model of the word.

// File: rtl/ep_pkg.sv
package ep_pkg;

    localparam int unsigned FIELD_W = 16;

    typedef enum logic [1:0] {
        ST_OFF   = 2'b00,
        ST_STALL = 2'b01,
        ST_NAK   = 2'b10,
        ST_LIVE  = 2'b11
    } ep_stat_e;

    typedef enum logic [1:0] {
        TY_BULK = 2'b00,
        TY_CTRL = 2'b01,
        TY_ISO  = 2'b10,
        TY_INTR = 2'b11
    } ep_type_e;

    // Packed MSB first: field positions are the register bit positions.
    typedef struct packed {
        logic       rx_vld;   // 15
        logic       rx_tog;   // 14
        ep_stat_e   rx_st;    // 13:12
        logic       setup;    // 11
        ep_type_e   typ;      // 10:9
        logic       kind;     // 8
        logic       tx_vld;   // 7
        logic       tx_tog;   // 6
        ep_stat_e   tx_st;    // 5:4
        logic [3:0] addr;     // 3:0
    } ep_state_t;

    typedef struct packed {
        logic in_ok;
        logic out_ok;
        logic setup_ok;
        logic iso_tx_eop;
        logic iso_rx_eop;
    } ep_events_t;

endpackage

// File: rtl/ep_sw_write.sv
module ep_sw_write
    import ep_pkg::*;
(
    input  ep_state_t              cur,
    input  logic                   wr_en,
    input  logic [FIELD_W-1:0]     wr_field,
    output ep_state_t              nxt
);
    ep_state_t wv;
    logic      unused_setup_bit;

    assign wv               = ep_state_t'(wr_field);
    assign unused_setup_bit = wv.setup;

    always_comb begin
        nxt = cur;
        if (wr_en) begin
            // plain fields
            nxt.addr   = wv.addr;
            nxt.kind   = wv.kind;
            nxt.typ    = wv.typ;
            // toggle-on-write fields
            nxt.tx_st  = ep_stat_e'(cur.tx_st ^ wv.tx_st);
            nxt.rx_st  = ep_stat_e'(cur.rx_st ^ wv.rx_st);
            nxt.tx_tog = cur.tx_tog ^ wv.tx_tog;
            nxt.rx_tog = cur.rx_tog ^ wv.rx_tog;
            // clear-only flags
            nxt.tx_vld = cur.tx_vld & wv.tx_vld;
            nxt.rx_vld = cur.rx_vld & wv.rx_vld;
        end
    end
endmodule

// File: rtl/ep_hw_update.sv
module ep_hw_update
    import ep_pkg::*;
(
    input  ep_type_e   typ_q,
    input  logic       rx_vld_q,
    input  ep_state_t  sw,
    input  ep_events_t ev,
    output ep_state_t  nxt
);
    logic is_iso;
    logic is_ctl;
    logic setup_open;

    assign is_iso     = (typ_q == TY_ISO);
    assign is_ctl     = (typ_q == TY_CTRL);
    assign setup_open = is_ctl && !rx_vld_q;

    always_comb begin
        nxt = sw;
        if (ev.in_ok) begin
            nxt.tx_vld = 1'b1;
            if (!is_iso) begin
                nxt.tx_st  = ST_NAK;
                nxt.tx_tog = ~nxt.tx_tog;
            end
        end
        if (ev.out_ok) begin
            nxt.rx_vld = 1'b1;
            if (!is_iso) begin
                nxt.rx_st  = ST_NAK;
                nxt.rx_tog = ~nxt.rx_tog;
            end
            if (setup_open) begin
                nxt.setup = 1'b0;
            end
        end
        if (ev.setup_ok && is_ctl) begin
            nxt.rx_vld = 1'b1;
            nxt.rx_st  = ST_NAK;
            nxt.tx_tog = 1'b1;
            nxt.rx_tog = 1'b0;
            if (setup_open) begin
                nxt.setup = 1'b1;
            end
        end
        if (is_iso && ev.iso_tx_eop) begin
            nxt.tx_tog = ~nxt.tx_tog;
        end
        if (is_iso && ev.iso_rx_eop) begin
            nxt.rx_tog = ~nxt.rx_tog;
        end
    end
endmodule

// File: rtl/ep_ctrl_reg.sv
module ep_ctrl_reg
    import ep_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ev_in_ok,
    input  logic              ev_out_ok,
    input  logic              ev_setup_ok,
    input  logic              ev_iso_tx_eop,
    input  logic              ev_iso_rx_eop,
    output logic [DATA_W-1:0] rd_data,
    output logic [3:0]        ep_addr,
    output logic [1:0]        ep_type,
    output logic              ep_kind,
    output logic [1:0]        tx_status,
    output logic              tx_toggle,
    output logic [1:0]        rx_status,
    output logic              rx_toggle,
    output logic              setup_seen,
    output logic              out_stall,
    output logic              irq
);
    localparam int unsigned PAD_W = DATA_W - FIELD_W;

    ep_state_t  state_q;
    ep_state_t  state_d;
    ep_state_t  sw_d;
    ep_state_t  hw_d;
    ep_events_t ev;
    logic       unused_hi;

    assign unused_hi = ^wr_data[DATA_W-1:FIELD_W];

    assign ev = '{in_ok:      ev_in_ok,
                  out_ok:     ev_out_ok,
                  setup_ok:   ev_setup_ok,
                  iso_tx_eop: ev_iso_tx_eop,
                  iso_rx_eop: ev_iso_rx_eop};

    ep_sw_write u_sw (
        .cur      (state_q),
        .wr_en    (wr_en),
        .wr_field (wr_data[FIELD_W-1:0]),
        .nxt      (sw_d)
    );

    ep_hw_update u_hw (
        .typ_q    (state_q.typ),
        .rx_vld_q (state_q.rx_vld),
        .sw       (sw_d),
        .ev       (ev),
        .nxt      (hw_d)
    );

    always_comb begin
        state_d = hw_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_data    = {{PAD_W{1'b0}}, state_q};
    assign ep_addr    = state_q.addr;
    assign ep_type    = state_q.typ;
    assign ep_kind    = state_q.kind;
    assign tx_status  = state_q.tx_st;
    assign tx_toggle  = state_q.tx_tog;
    assign rx_status  = state_q.rx_st;
    assign rx_toggle  = state_q.rx_tog;
    assign setup_seen = state_q.setup;
    assign out_stall  = (state_q.typ == TY_CTRL) && state_q.kind;
    assign irq        = state_q.tx_vld | state_q.rx_vld;
endmodule

// File: rtl/ep_ctrl_reg_chk.sv
module ep_ctrl_reg_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              ev_in_ok,
    input logic              ev_out_ok,
    input logic              ev_setup_ok,
    input logic [DATA_W-1:0] rd_data,
    input logic [1:0]        ep_type,
    input logic [1:0]        tx_status,
    input logic              tx_toggle,
    input logic [1:0]        rx_status,
    input logic              rx_toggle,
    input logic              setup_seen,
    input logic              irq
);
    AST_IRQ_FOLLOWS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (rd_data[7] | rd_data[15])); // R11

    AST_IN_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ev_in_ok |=> rd_data[7]); // R5

    AST_IN_FORCES_NAK: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_in_ok && ep_type != 2'b10) |=> tx_status == 2'b10); // R5

    AST_OUT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ev_out_ok |=> rd_data[15]); // R6

    AST_SETUP_PRESETS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_setup_ok && ep_type == 2'b01) |=> (tx_toggle && !rx_toggle && rx_status == 2'b10)); // R7

    AST_ISO_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_type == 2'b10 && !wr_en) |=> ($stable(tx_status) && $stable(rx_status))); // R8

    AST_SETUP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[15] |=> $stable(setup_seen)); // R9

    AST_TX_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[7] && !ev_in_ok) |=> !rd_data[7]); // R4
endmodule

bind ep_ctrl_reg ep_ctrl_reg_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .ev_in_ok    (ev_in_ok),
    .ev_out_ok   (ev_out_ok),
    .ev_setup_ok (ev_setup_ok),
    .rd_data     (rd_data),
    .ep_type     (ep_type),
    .tx_status   (tx_status),
    .tx_toggle   (tx_toggle),
    .rx_status   (rx_status),
    .rx_toggle   (rx_toggle),
    .setup_seen  (setup_seen),
    .irq         (irq)
);

// File: tb/sim_ep_ctrl_reg.sv
`timescale 1ns/1ps
module sim_ep_ctrl_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        ev_in_ok = 1'b0, ev_out_ok = 1'b0, ev_setup_ok = 1'b0;
    logic        ev_iso_tx_eop = 1'b0, ev_iso_rx_eop = 1'b0;
    logic [31:0] rd_data;
    logic [3:0]  ep_addr;
    logic [1:0]  ep_type, tx_status, rx_status;
    logic        ep_kind, tx_toggle, rx_toggle, setup_seen, out_stall, irq;

    int unsigned n_chk = 0;
    int unsigned n_fail = 0;
    logic        done = 1'b0;
    logic [15:0] exp_w = '0;
    logic [31:0] rng = 32'h1234_5678;

    always #4 clk = ~clk;

    ep_ctrl_reg u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .ev_in_ok(ev_in_ok), .ev_out_ok(ev_out_ok), .ev_setup_ok(ev_setup_ok),
        .ev_iso_tx_eop(ev_iso_tx_eop), .ev_iso_rx_eop(ev_iso_rx_eop),
        .rd_data(rd_data), .ep_addr(ep_addr), .ep_type(ep_type), .ep_kind(ep_kind),
        .tx_status(tx_status), .tx_toggle(tx_toggle), .rx_status(rx_status),
        .rx_toggle(rx_toggle), .setup_seen(setup_seen), .out_stall(out_stall), .irq(irq)
    );

    // Expected word from the requirements. ev: 0 in, 1 out, 2 setup, 3 iso tx eop, 4 iso rx eop.
    function automatic logic [15:0] mdl(input logic [15:0] s, input logic we,
                                        input logic [15:0] w, input logic [4:0] ev);
        logic [15:0] n;
        logic        iso, ctl;
        n   = s;
        iso = (s[10:9] == 2'b10);
        ctl = (s[10:9] == 2'b01);
        if (we) begin
            n[3:0]   = w[3:0];
            n[5:4]   = s[5:4] ^ w[5:4];
            n[6]     = s[6] ^ w[6];
            n[7]     = s[7] & w[7];
            n[8]     = w[8];
            n[10:9]  = w[10:9];
            n[13:12] = s[13:12] ^ w[13:12];
            n[14]    = s[14] ^ w[14];
            n[15]    = s[15] & w[15];
        end
        if (ev[0]) begin
            n[7] = 1'b1;
            if (!iso) begin n[5:4] = 2'b10; n[6] = ~n[6]; end
        end
        if (ev[1]) begin
            n[15] = 1'b1;
            if (!iso) begin n[13:12] = 2'b10; n[14] = ~n[14]; end
            if (ctl && !s[15]) n[11] = 1'b0;
        end
        if (ev[2] && ctl) begin
            n[15] = 1'b1; n[13:12] = 2'b10; n[6] = 1'b1; n[14] = 1'b0;
            if (!s[15]) n[11] = 1'b1;
        end
        if (ev[3] && iso) n[6]  = ~n[6];
        if (ev[4] && iso) n[14] = ~n[14];
        return n;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic look(input string tag);
        chk({tag, " word"}, rd_data, {16'h0000, exp_w});
        chk({tag, " R11 irq"}, {31'd0, irq}, {31'd0, exp_w[7] | exp_w[15]});
        chk({tag, " R10 stall"}, {31'd0, out_stall}, {31'd0, (exp_w[10:9] == 2'b01) && exp_w[8]});
        chk({tag, " fields"}, {18'd0, ep_addr, ep_type, ep_kind, tx_status, tx_toggle,
                               rx_status, rx_toggle, setup_seen},
            {18'd0, exp_w[3:0], exp_w[10:9], exp_w[8], exp_w[5:4], exp_w[6],
             exp_w[13:12], exp_w[14], exp_w[11]});
    endtask

    task automatic step(input logic we, input logic [15:0] wd, input logic [4:0] ev,
                        input string tag);
        @(negedge clk);
        wr_en         = we;
        wr_data       = {rng[31:16], wd};
        ev_in_ok      = ev[0];
        ev_out_ok     = ev[1];
        ev_setup_ok   = ev[2];
        ev_iso_tx_eop = ev[3];
        ev_iso_rx_eop = ev[4];
        exp_w         = mdl(exp_w, we, wd, ev);
        @(posedge clk);
        #2;
        wr_en = 1'b0; ev_in_ok = 1'b0; ev_out_ok = 1'b0; ev_setup_ok = 1'b0;
        ev_iso_tx_eop = 1'b0; ev_iso_rx_eop = 1'b0;
        look(tag);
    endtask

    function automatic logic [31:0] nxt_rng(input logic [31:0] r);
        logic [31:0] x;
        x = r;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        look("R1 reset");
        @(negedge clk);
        rst_n = 1'b1;

        step(1'b1, 16'hFFFF, 5'd0, "R2 all ones");
        step(1'b1, 16'h0800, 5'd0, "R2 setup bit ignored");
        step(1'b1, 16'h7070, 5'd0, "R3 toggle status");
        step(1'b1, 16'h0000, 5'd0, "R3 zeros keep");
        step(1'b0, 16'h0000, 5'd1, "R5 in bulk");
        step(1'b0, 16'h0000, 5'd2, "R6 out bulk");
        step(1'b1, 16'h8080, 5'd0, "R4 write ones keep");
        step(1'b1, 16'h8000, 5'd0, "R4 clear tx");
        step(1'b1, 16'h0000, 5'd0, "R4 clear rx");
        step(1'b0, 16'h0000, 5'd4, "R7 setup on bulk ignored");
        step(1'b1, 16'h0200, 5'd0, "R7 make control");
        step(1'b0, 16'h0000, 5'd4, "R7 setup control");
        step(1'b0, 16'h0000, 5'd2, "R9 frozen while valid");
        step(1'b1, 16'h0200, 5'd0, "R9 clear rx valid");
        step(1'b0, 16'h0000, 5'd2, "R9 out clears flag");
        step(1'b1, 16'h0300, 5'd0, "R10 control kind");
        step(1'b1, 16'h0500, 5'd0, "R8 make iso");
        step(1'b0, 16'h0000, 5'd3, "R8 iso completions");
        step(1'b0, 16'h0000, 5'd8, "R8 iso tx eop");
        step(1'b0, 16'h0000, 5'd16, "R8 iso rx eop");
        step(1'b1, 16'h0000, 5'd0, "R8 back to bulk");
        step(1'b0, 16'h0000, 5'd24, "R8 eop on bulk ignored");
        step(1'b0, 16'h0000, 5'd1, "R12 prep");
        step(1'b1, 16'h0030, 5'd1, "R12 clear with in");
        step(1'b1, 16'h0200, 5'd4, "R12 type change with setup");

        for (int t = 0; t < 4; t++) begin
            for (int e = 0; e < 32; e++) begin
                for (int p = 0; p < 4; p++) begin
                    rng = nxt_rng(rng);
                    step(1'b1, {rng[15:11], t[1:0], p[0], rng[7:0]}, 5'd0, "R12 sweep cfg");
                    step(1'b0, 16'h0000, {3'b000, p[1], p[0]}, "R12 sweep pre");
                    rng = nxt_rng(rng);
                    step(rng[20], {rng[15:11], t[1:0], rng[8:0]}, e[4:0], "R12 sweep event");
                end
            end
        end

        for (int i = 0; i < 12000; i++) begin
            rng = nxt_rng(rng);
            step(rng[31], rng[15:0], rng[24:20] & rng[29:25], "R12 random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule